// File: doc/BRIEF.md
# Conversion Result Holding Register

This block holds the most recent finished conversion result in one place that several request sources share. The converter offers each result on a one-cycle store strobe. The strobe carries a 15-bit data value and its tags: the group number, the channel number, the external multiplexer setting, the request source and the fast-compare outcome. The block packs these into a single 32-bit word. A valid flag in that word marks data that software has not yet consumed. A separate sticky result-event flag records that a store happened. When enabled, a one-cycle service request is raised for each store.

Two storage policies are chosen by a control bit. In overwrite mode every store replaces the held word. In wait-for-read mode a store is refused while the valid flag is set. A refusal raises a stall indication toward the converter, and the stall holds until the flag is cleared. The flag is cleared in one of two ways. A normal bus read of the word clears it. A software clear strobe also clears it, and this clear wins over a hardware set in the same cycle. A debug read path presents the same word and leaves the flag alone. Data reduction, limit checking and the converter itself are outside this block.

Top module: `result_hold_reg`

## Requirements
- R1: The result word places data in bits 14:0, the group number in 18:16, the channel number in 23:20, the multiplexer setting in 26:25, the request-source bit at 28, the fast-compare bit at 30 and the valid flag at 31. Bits 15, 19, 24, 27 and 29 read 0. The fast-compare input is stored unchanged (1 = above the compare value).
- R2: After reset the word is all zero, and ev_flag, srq and cv_stall are 0. Both control bits (wait-for-read and request enable) are 0.
- R3: In overwrite mode (control bit wfr=0), every store strobe replaces the held word. The new word is visible on the first rising edge after the strobe, with the valid flag set.
- R4: In wait-for-read mode (wfr=1), a store strobe that arrives while the valid flag is 1 is refused and the word does not change. cv_stall goes high from the next edge and stays high until the valid flag is cleared. A store offered while the flag is 0 is accepted.
- R5: A software clear strobe (sw_vclr) clears the valid flag at the next edge. It wins over a store in the same cycle; in that case the data fields still update in overwrite mode.
- R6: A bus read strobe (rd_main) clears the valid flag at the next edge, unless a store is accepted in the same cycle. A debug read strobe (rd_dbg) changes nothing, and dbg_word always equals res_word.
- R7: Every accepted store sets ev_flag. The write-only clear strobe ev_clr clears it, but a store in the same cycle wins over the clear.
- R8: With the request-enable bit set, each accepted store produces srq high for exactly the cycle in which the new word first appears. With the bit clear, srq stays 0.
- R9: The control bits wfr and request-enable load from ctrl_wfr and ctrl_sren only on a ctrl_we strobe. The new values govern stores from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_wr | input | 1 | Store strobe from the converter |
| cv_data | input | 15 | Conversion data |
| cv_grp | input | 3 | Group number tag |
| cv_chan | input | 4 | Channel number tag |
| cv_mux | input | 2 | External multiplexer setting tag |
| cv_src | input | 1 | Request-source tag |
| cv_cmp | input | 1 | Fast-compare outcome |
| cv_stall | output | 1 | Store refused; wait until the valid flag clears |
| rd_main | input | 1 | Bus read of the result word (clears valid) |
| rd_dbg | input | 1 | Debug read of the result word (no side effect) |
| sw_vclr | input | 1 | Software clear of the valid flag |
| ev_clr | input | 1 | Clear command for the result-event flag |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wfr | input | 1 | Wait-for-read value to load |
| ctrl_sren | input | 1 | Service-request enable value to load |
| res_word | output | 32 | Packed result word |
| dbg_word | output | 32 | Same word on the debug read path |
| ev_flag | output | 1 | Result-event flag |
| srq | output | 1 | Service request pulse |

## Verification
A wrong valid flag shows in bit 31 of both words one edge after the strobe that should have moved it. In wait-for-read mode it also shows at once as a wrong accept or refuse decision: the word fails to change, or changes when it should not, and cv_stall follows on the next edge. A wrong event or request path shows in ev_flag and srq in the same cycle as the new word. A reference model updated on every edge compares all outputs each cycle, so any such deviation is reported within one cycle of its cause.

// File: rtl/res_pkg.sv
package res_pkg;
  localparam int DATA_W = 15;
  localparam int GRP_W  = 3;
  localparam int CHAN_W = 4;
  localparam int MUX_W  = 2;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [GRP_W-1:0]  grp;
    logic [CHAN_W-1:0] chan;
    logic [MUX_W-1:0]  mux;
    logic              src;
    logic              cmp;
  } res_tag_t;

  // Field placement is fixed: a downstream reader decodes these positions.
  function automatic logic [WORD_W-1:0] pack_word(input res_tag_t t, input logic valid);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[14:0]  = t.data;
    w[18:16] = t.grp;
    w[23:20] = t.chan;
    w[26:25] = t.mux;
    w[28]    = t.src;
    w[30]    = t.cmp;
    w[31]    = valid;
    return w;
  endfunction
endpackage

// File: rtl/res_flags.sv
module res_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic store_req,
  input  logic wfr,
  input  logic rd_clr,
  input  logic rd_dbg,
  input  logic sw_vclr,
  input  logic ev_clr,
  output logic accept,
  output logic reject,
  output logic valid_q,
  output logic ev_q,
  output logic stall_q
);
  logic valid_d;

  assign accept = store_req && (!wfr || !valid_q);
  assign reject = store_req && wfr && valid_q;

  always_comb begin
    if (sw_vclr)     valid_d = 1'b0;
    else if (accept) valid_d = 1'b1;
    else if (rd_clr) valid_d = 1'b0;
    else             valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ev_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (accept)      ev_q <= 1'b1;
      else if (ev_clr) ev_q <= 1'b0;
      stall_q <= (stall_q || reject) && valid_d && wfr;
    end
  end

  // R5
  vclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vclr |=> !valid_q);
  // R3
  store_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sw_vclr) |=> valid_q);
  // R4
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> valid_q);
  // R6
  dbg_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dbg && valid_q && !rd_clr && !sw_vclr) |=> valid_q);
  // R7
  store_sets_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ev_q);
endmodule

// File: rtl/res_store.sv
module res_store
  import res_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     reject,
  input  res_tag_t din,
  output res_tag_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (accept) held <= din;
  end

  // R4
  refused_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(held));
endmodule

// File: rtl/res_srq.sv
module res_srq (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic sren,
  output logic srq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srq_q <= 1'b0;
    else        srq_q <= accept && sren;
  end

  // R8
  srq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sren |=> !srq_q);
endmodule

// File: rtl/result_hold_reg.sv
module result_hold_reg
  import res_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_wr,
  input  logic [DATA_W-1:0] cv_data,
  input  logic [GRP_W-1:0]  cv_grp,
  input  logic [CHAN_W-1:0] cv_chan,
  input  logic [MUX_W-1:0]  cv_mux,
  input  logic              cv_src,
  input  logic              cv_cmp,
  output logic              cv_stall,
  input  logic              rd_main,
  input  logic              rd_dbg,
  input  logic              sw_vclr,
  input  logic              ev_clr,
  input  logic              ctrl_we,
  input  logic              ctrl_wfr,
  input  logic              ctrl_sren,
  output logic [WORD_W-1:0] res_word,
  output logic [WORD_W-1:0] dbg_word,
  output logic              ev_flag,
  output logic              srq
);
  logic     wfr_q, sren_q;
  logic     accept, reject, valid_q, ev_q, stall_q, srq_q;
  res_tag_t din, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wfr_q  <= 1'b0;
      sren_q <= 1'b0;
    end else if (ctrl_we) begin
      wfr_q  <= ctrl_wfr;
      sren_q <= ctrl_sren;
    end
  end

  assign din = '{data: cv_data, grp: cv_grp, chan: cv_chan,
                 mux: cv_mux, src: cv_src, cmp: cv_cmp};

  res_flags u_flags (
    .clk(clk), .rst_n(rst_n), .store_req(cv_wr), .wfr(wfr_q),
    .rd_clr(rd_main), .rd_dbg(rd_dbg), .sw_vclr(sw_vclr), .ev_clr(ev_clr),
    .accept(accept), .reject(reject), .valid_q(valid_q), .ev_q(ev_q),
    .stall_q(stall_q)
  );

  res_store u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .reject(reject),
    .din(din), .held(held)
  );

  res_srq u_srq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sren(sren_q), .srq_q(srq_q)
  );

  assign res_word = pack_word(held, valid_q);
  assign dbg_word = res_word;
  assign ev_flag  = ev_q;
  assign srq      = srq_q;
  assign cv_stall = stall_q;

  // R8
  srq_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> ev_flag);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_word[15] | res_word[19] | res_word[24] | res_word[27] | res_word[29]) == 1'b0);
endmodule

// File: tb/sim_result_hold_reg.sv
module sim_result_hold_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cv_wr = 0, cv_src = 0, cv_cmp = 0, rd_main = 0, rd_dbg = 0;
  logic sw_vclr = 0, ev_clr = 0, ctrl_we = 0, ctrl_wfr = 0, ctrl_sren = 0;
  logic [14:0] cv_data = 0;
  logic [2:0]  cv_grp = 0;
  logic [3:0]  cv_chan = 0;
  logic [1:0]  cv_mux = 0;
  logic        cv_stall, ev_flag, srq;
  logic [31:0] res_word, dbg_word;

  always #2 clk = ~clk;

  result_hold_reg u0 (
    .clk(clk), .rst_n(rst_n), .cv_wr(cv_wr), .cv_data(cv_data), .cv_grp(cv_grp),
    .cv_chan(cv_chan), .cv_mux(cv_mux), .cv_src(cv_src), .cv_cmp(cv_cmp),
    .cv_stall(cv_stall), .rd_main(rd_main), .rd_dbg(rd_dbg), .sw_vclr(sw_vclr),
    .ev_clr(ev_clr), .ctrl_we(ctrl_we), .ctrl_wfr(ctrl_wfr), .ctrl_sren(ctrl_sren),
    .res_word(res_word), .dbg_word(dbg_word), .ev_flag(ev_flag), .srq(srq)
  );

  // Reference model
  int    m_data, m_grp, m_chan, m_mux, m_src, m_cmp;
  bit    m_valid, m_ev, m_stall, m_srq, m_wfr, m_sren;
  int    errors = 0, checks = 0;
  string tag = "R2";
  bit    finished = 0;

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = (32'(m_valid) << 31) | (32'(m_cmp) << 30) | (32'(m_src) << 28)
      | (32'(m_mux) << 25) | (32'(m_chan) << 20) | (32'(m_grp) << 16) | 32'(m_data);
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_grp = 0; m_chan = 0; m_mux = 0; m_src = 0; m_cmp = 0;
      m_valid = 0; m_ev = 0; m_stall = 0; m_srq = 0; m_wfr = 0; m_sren = 0;
    end else begin
      bit acc, rej, nv;
      acc = cv_wr && !(m_wfr && m_valid);
      rej = cv_wr && m_wfr && m_valid;
      if (acc) begin
        m_data = cv_data; m_grp = cv_grp; m_chan = cv_chan;
        m_mux = cv_mux; m_src = cv_src; m_cmp = cv_cmp;
      end
      if (sw_vclr) nv = 0;
      else if (acc) nv = 1;
      else if (rd_main) nv = 0;
      else nv = m_valid;
      m_stall = (m_stall || rej) && nv && m_wfr;
      m_valid = nv;
      if (acc) m_ev = 1; else if (ev_clr) m_ev = 0;
      m_srq = acc && m_sren;
      if (ctrl_we) begin m_wfr = ctrl_wfr; m_sren = ctrl_sren; end
    end
  end

  task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("res_word", res_word, model_word());
    chk("dbg_word", dbg_word, model_word());
    chk("ev_flag", 32'(ev_flag), 32'(m_ev));
    chk("srq", 32'(srq), 32'(m_srq));
    chk("cv_stall", 32'(cv_stall), 32'(m_stall));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    cv_wr = 0; rd_main = 0; rd_dbg = 0; sw_vclr = 0; ev_clr = 0; ctrl_we = 0;
  endtask

  task automatic offer(input int d, input int g, input int c, input int mx,
                       input bit s, input bit cm);
    cv_wr = 1; cv_data = 15'(d); cv_grp = 3'(g); cv_chan = 4'(c);
    cv_mux = 2'(mx); cv_src = s; cv_cmp = cm;
  endtask

  task automatic set_ctrl(input bit w, input bit s);
    ctrl_we = 1; ctrl_wfr = w; ctrl_sren = s;
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R2";
    chk("reset word r2_", res_word, 32'h0);
    chk("reset flags R2", {29'b0, ev_flag, srq, cv_stall}, 32'h0);
    rst_n = 1;
    step();

    tag = "R1";
    set_ctrl(0, 1);
    offer(15'h7ABC, 5, 9, 3, 1, 1); step();
    step();
    chk("packed layout R1", res_word, 32'hD6_95_7ABC | 32'h0);
    tag = "R3";
    offer(15'h0123, 2, 4, 1, 0, 0); step();
    offer(15'h0456, 7, 15, 2, 1, 0); step();
    chk("overwrite R3", res_word & 32'h7FFF, 32'h0456);
    chk("srq back-to-back R8", 32'(srq), 32'h1);
    step();

    tag = "R6";
    rd_dbg = 1; step();
    chk("debug read keeps valid R6", 32'(res_word[31]), 32'h1);
    rd_main = 1; step();
    chk("bus read clears valid R6", 32'(res_word[31]), 32'h0);

    tag = "R5";
    sw_vclr = 1; offer(15'h1111, 1, 1, 1, 1, 1); step();
    chk("clear wins valid R5", 32'(res_word[31]), 32'h0);
    chk("data still stored R5", res_word & 32'h7FFF, 32'h1111);

    tag = "R7";
    ev_clr = 1; step();
    chk("event cleared R7", 32'(ev_flag), 32'h0);
    ev_clr = 1; offer(15'h2222, 0, 0, 0, 0, 0); step();
    chk("store beats event clear R7", 32'(ev_flag), 32'h1);

    tag = "R8";
    set_ctrl(0, 0);
    offer(15'h3333, 0, 0, 0, 0, 0); step();
    chk("no srq when disabled R8", 32'(srq), 32'h0);

    tag = "R9";
    ctrl_wfr = 1; ctrl_sren = 1; step();
    offer(15'h0AAA, 0, 0, 0, 0, 0); step();
    chk("ctrl ignored without strobe R9", res_word & 32'h7FFF, 32'h0AAA);

    tag = "R4";
    set_ctrl(1, 1);
    sw_vclr = 1; step();
    offer(15'h0101, 1, 2, 3, 0, 1); step();
    offer(15'h0202, 2, 3, 0, 1, 0); step();
    chk("refused store keeps word R4", res_word & 32'h7FFF, 32'h0101);
    chk("stall raised R4", 32'(cv_stall), 32'h1);
    step(); step();
    chk("stall holds R4", 32'(cv_stall), 32'h1);
    rd_main = 1; step();
    chk("stall drops on read R4", 32'(cv_stall), 32'h0);
    offer(15'h0303, 0, 0, 0, 0, 0); step();
    chk("store accepted after read R4", res_word & 32'h7FFF, 32'h0303);

    tag = "R3";
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 0) begin ctrl_we = 1; ctrl_wfr = $urandom_range(0, 1); ctrl_sren = $urandom_range(0, 1); end
      if ($urandom_range(0, 2) != 0)
        offer($urandom_range(0, 32767), $urandom_range(0, 7), $urandom_range(0, 15),
              $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      rd_main = ($urandom_range(0, 4) == 0);
      rd_dbg  = ($urandom_range(0, 3) == 0);
      sw_vclr = ($urandom_range(0, 9) == 0);
      ev_clr  = ($urandom_range(0, 5) == 0);
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule